// File: doc/BRIEF.md
# Power-Up I2C Register Write Sequencer

After reset this block configures a video encoder over I2C with no help from software. It runs through a small parameter table of (register offset, data) pairs. For each entry it performs one complete write: a START condition, the 7-bit device address with a write bit, the offset byte, the data byte, and a STOP condition. The device address defaults to 0x76. Every byte is followed by an acknowledge clock. The sequence moves on only when that acknowledge is valid. At the first missing acknowledge, the bus is closed with a STOP and an error flag is raised.

Both bus lines are open-drain. The block asserts an output-enable to pull a line low and reads the real line level back through a separate input. A prescaler divides the system clock into quarter-bit ticks, giving a standard-mode SCL by default. The default table holds a single entry, because normal use needs only the input-format register written while every other register keeps its reset value. `busy` is high from reset until the final STOP. On success, `done` pulses for one cycle.

Top module: `i2c_cfg_seq`

## Requirements
- R1: While reset is held and after it is released, `busy` is 1, and the sequence starts with no other trigger. `busy` falls only in the cycle that ends the run, which is the same cycle as the `done` pulse or the `error` rise.
- R2: The first byte of every write is the device address shifted left by one, with bit 0 (the R/W bit) set to 0 for write. For address 0x76 this is 0xEC. Every byte goes out MSB first.
- R3: Each table entry i becomes START, address byte, byte [16i+15:16i+8] of the table (offset), byte [16i+7:16i] (data), and STOP. Entries are sent in increasing i, with one START and one STOP per entry.
- R4: SDA changes while SCL is high only for a START (SDA falls) or a STOP (SDA rises).
- R5: On the ninth clock of each byte the block releases SDA and samples it while SCL is high. A low level is ACK and a high level is NACK.
- R6: After a NACK on any byte, the block sends no further bytes, issues a STOP, raises `error` and keeps it high until reset. `done` never pulses in that run.
- R7: When every byte is acknowledged, `done` is high for exactly one cycle after the last STOP.
- R8: During a byte, SCL is high for 2*Q system clocks of each 4*Q clock bit, where Q = CLK_HZ/(4*SCL_HZ).
- R9: A START is issued only after both `scl_i` and `sda_i` have been seen high. While either line is held low, neither output-enable is asserted.
- R10: Once `busy` is low, both output-enables stay 0 and the block stays idle until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the sequence starts when it is released |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | High until the sequence ends |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Sticky flag set after a missing acknowledge |

## Verification
The assertions are checked on every cycle for the following:
- SDA stays steady under a high SCL, except inside a START or STOP.
- The `done` pulse is a single cycle and coincides with the fall of `busy`.
- `error` is sticky and excludes `done`.
- The bus is released and quiet once `busy` is low.

Only the bench's scenarios can show the following, because they depend on what a responding device does:
- the byte stream that an emulated target decodes, in order;
- which bytes are refused and what happens after a refusal at each position;
- the measured SCL high time;
- the wait while the bus is held low at start-up.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  // Operations handed from the sequencer to the bus engine
  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_BYTE  = 2'd1,
    BUS_STOP  = 2'd2
  } bus_op_e;

  // Bus engine states
  typedef enum logic [2:0] {
    ENG_IDLE  = 3'd0,
    ENG_FREE  = 3'd1,
    ENG_START = 3'd2,
    ENG_BYTE  = 3'd3,
    ENG_STOP  = 3'd4
  } eng_st_e;

  // Sequencer states
  typedef enum logic [2:0] {
    SQ_START = 3'd0,
    SQ_ADDR  = 3'd1,
    SQ_OFS   = 3'd2,
    SQ_DATA  = 3'd3,
    SQ_STOP  = 3'd4,
    SQ_ABORT = 3'd5,
    SQ_DONE  = 3'd6,
    SQ_FAIL  = 3'd7
  } seq_st_e;

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int QUARTER = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cfg_table.sv
module i2c_cfg_table #(
  parameter int                       NUM_WRITES = 1,
  parameter int                       IW         = 1,
  parameter logic [NUM_WRITES*16-1:0] CFG_TABLE  = '0
) (
  input  logic          clk,
  input  logic [IW-1:0] idx,
  output logic [7:0]    ofs_q,
  output logic [7:0]    dat_q
);
  logic [15:0] rom [NUM_WRITES];

  for (genvar g = 0; g < NUM_WRITES; g++) begin : g_fill
    assign rom[g] = CFG_TABLE[g*16 +: 16];
  end

  // Registered read so the table maps onto block memory
  if (NUM_WRITES == 1) begin : g_one
    logic unused_idx;
    assign unused_idx = ^idx;
    always_ff @(posedge clk) begin
      {ofs_q, dat_q} <= rom[0];
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      {ofs_q, dat_q} <= rom[idx];
    end
  end
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
  import i2c_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    op_vld,
  input  bus_op_e op,
  input  logic [7:0] op_byte,
  input  logic    scl_i,
  input  logic    sda_i,
  output logic    op_done,
  output logic    op_ack,
  output logic    scl_oe,
  output logic    sda_oe,
  output logic    edge_win
);
  eng_st_e    st_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic [8:0] sh_q;

  assign edge_win = (st_q == ENG_START) || (st_q == ENG_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ENG_IDLE;
      ph_q    <= 2'd0;
      bit_q   <= 4'd0;
      sh_q    <= 9'd0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      op_done <= 1'b0;
      op_ack  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      case (st_q)
        ENG_IDLE: begin
          if (op_vld) begin
            ph_q <= 2'd0;
            case (op)
              BUS_START: st_q <= ENG_FREE;
              BUS_BYTE: begin
                st_q  <= ENG_BYTE;
                sh_q  <= {op_byte, 1'b1};
                bit_q <= 4'd0;
              end
              default: st_q <= ENG_STOP;
            endcase
          end
        end
        ENG_FREE: begin
          if (tick && scl_i && sda_i) st_q <= ENG_START;
        end
        ENG_START: begin
          if (tick) begin
            ph_q <= ph_q + 2'd1;
            case (ph_q)
              2'd0: sda_oe <= 1'b1;
              2'd2: scl_oe <= 1'b1;
              2'd3: begin
                st_q    <= ENG_IDLE;
                op_done <= 1'b1;
                op_ack  <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ENG_BYTE: begin
          if (tick) begin
            ph_q <= ph_q + 2'd1;
            case (ph_q)
              2'd0: sda_oe <= ~sh_q[8];
              2'd1: scl_oe <= 1'b0;
              2'd2: op_ack <= ~sda_i;
              default: begin
                scl_oe <= 1'b1;
                sh_q   <= {sh_q[7:0], 1'b0};
                if (bit_q == 4'd8) begin
                  st_q    <= ENG_IDLE;
                  op_done <= 1'b1;
                end else begin
                  bit_q <= bit_q + 4'd1;
                end
              end
            endcase
          end
        end
        ENG_STOP: begin
          if (tick) begin
            ph_q <= ph_q + 2'd1;
            case (ph_q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                st_q    <= ENG_IDLE;
                op_done <= 1'b1;
              end
            endcase
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_WRITES = 1,
  parameter int         IW         = 1,
  parameter logic [6:0] DEV_ADDR   = 7'h76
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_done,
  input  logic          op_ack,
  input  logic [7:0]    ofs,
  input  logic [7:0]    dat,
  output logic          op_vld,
  output bus_op_e       op,
  output logic [7:0]    op_byte,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WRITES - 1);
  localparam logic [7:0]    ADDR_WR  = {DEV_ADDR, 1'b0};

  seq_st_e st_q;
  logic    wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_START;
      wait_q  <= 1'b0;
      idx     <= '0;
      busy    <= 1'b1;
      done    <= 1'b0;
      error   <= 1'b0;
      op_vld  <= 1'b0;
      op      <= BUS_START;
      op_byte <= 8'h00;
    end else begin
      op_vld <= 1'b0;
      done   <= 1'b0;
      if (st_q != SQ_DONE && st_q != SQ_FAIL) begin
        if (!wait_q) begin
          op_vld <= 1'b1;
          wait_q <= 1'b1;
          case (st_q)
            SQ_START: begin op <= BUS_START; op_byte <= 8'h00;   end
            SQ_ADDR:  begin op <= BUS_BYTE;  op_byte <= ADDR_WR; end
            SQ_OFS:   begin op <= BUS_BYTE;  op_byte <= ofs;     end
            SQ_DATA:  begin op <= BUS_BYTE;  op_byte <= dat;     end
            default:  begin op <= BUS_STOP;  op_byte <= 8'h00;   end
          endcase
        end else if (op_done) begin
          wait_q <= 1'b0;
          case (st_q)
            SQ_START: st_q <= SQ_ADDR;
            SQ_ADDR:  st_q <= op_ack ? SQ_OFS  : SQ_ABORT;
            SQ_OFS:   st_q <= op_ack ? SQ_DATA : SQ_ABORT;
            SQ_DATA:  st_q <= op_ack ? SQ_STOP : SQ_ABORT;
            SQ_STOP: begin
              if (idx == LAST_IDX) begin
                st_q <= SQ_DONE;
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                idx  <= idx + 1'b1;
                st_q <= SQ_START;
              end
            end
            default: begin
              st_q  <= SQ_FAIL;
              busy  <= 1'b0;
              error <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_seq.sv
module i2c_cfg_seq
  import i2c_cfg_pkg::*;
#(
  parameter int                       CLK_HZ     = 50_000_000,
  parameter int                       SCL_HZ     = 100_000,
  parameter logic [6:0]               DEV_ADDR   = 7'h76,
  parameter int                       NUM_WRITES = 1,
  parameter logic [NUM_WRITES*16-1:0] CFG_TABLE  = 16'h0D21
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic error
);
  localparam int QRAW    = CLK_HZ / (4 * SCL_HZ);
  localparam int QUARTER = (QRAW < 1) ? 1 : QRAW;
  localparam int IW      = (NUM_WRITES > 1) ? $clog2(NUM_WRITES) : 1;

  logic          tick;
  logic          op_vld, op_done, op_ack;
  bus_op_e       op;
  logic [7:0]    op_byte, ofs, dat;
  logic [IW-1:0] idx;
  logic          edge_win;

  i2c_quarter_tick #(.QUARTER(QUARTER)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  i2c_cfg_table #(
    .NUM_WRITES(NUM_WRITES),
    .IW        (IW),
    .CFG_TABLE (CFG_TABLE)
  ) u_table (
    .clk  (clk),
    .idx  (idx),
    .ofs_q(ofs),
    .dat_q(dat)
  );

  i2c_cfg_ctrl #(
    .NUM_WRITES(NUM_WRITES),
    .IW        (IW),
    .DEV_ADDR  (DEV_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .op_done(op_done),
    .op_ack (op_ack),
    .ofs    (ofs),
    .dat    (dat),
    .op_vld (op_vld),
    .op     (op),
    .op_byte(op_byte),
    .idx    (idx),
    .busy   (busy),
    .done   (done),
    .error  (error)
  );

  i2c_bus_engine u_eng (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .op_vld  (op_vld),
    .op      (op),
    .op_byte (op_byte),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .op_done (op_done),
    .op_ack  (op_ack),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .edge_win(edge_win)
  );
endmodule

// File: rtl/i2c_cfg_seq_chk.sv
module i2c_cfg_seq_chk (
  input logic clk,
  input logic rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done,
  input logic error,
  input logic edge_win
);
  // R4: SDA moves under a high SCL only inside START/STOP
  a_r4_sda_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> edge_win);

  // R6: error is sticky
  a_r6_error_sticky: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  // R6: no done in a failed run
  a_r6_no_done_on_error: assert property (@(posedge clk) disable iff (rst)
    error |-> !done);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: busy falls only together with done or error
  a_r1_busy_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || error));

  // R10: lines released after the run
  a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  // R10: stays idle until reset
  a_r10_stays_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);
endmodule

bind i2c_cfg_seq i2c_cfg_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .busy    (busy),
  .done    (done),
  .error   (error),
  .edge_win(edge_win)
);

// File: tb/i2c_cfg_seq_tb.sv
module i2c_cfg_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_600_000;
  localparam int SCL_HZ     = 100_000;
  localparam int Q          = CLK_HZ / (4 * SCL_HZ);
  localparam int HI_TIME    = 2 * Q * CLK_PERIOD;
  localparam logic [31:0] TBL = {16'h0760, 16'h0D1B};

  logic clk = 1'b0, rst = 1'b1;
  logic scl_oe, sda_oe, busy, done, error;
  logic ack_pull = 1'b0, hold_pull = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | ack_pull | hold_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_seq #(
    .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .DEV_ADDR(7'h76),
    .NUM_WRITES(2), .CFG_TABLE(TBL)
  ) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .error(error)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] stream [6] = '{8'hEC, 8'h0D, 8'h1B, 8'hEC, 8'h07, 8'h60};

  int start_cnt, stop_cnt, byte_no, done_cnt, hi_bad, nack_at;
  bit in_frame;
  int bitcnt;
  logic [7:0] shreg;
  time t_rise;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard
  task automatic push_exp(int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(stream[i]);
      tag_q.push_back((i % 3 == 0) ? "R2 address byte" : "R3 payload byte");
    end
  endtask

  // Target model and monitor
  always @(negedge sda_line) if (scl_line === 1'b1) begin
    start_cnt++; in_frame = 1; bitcnt = 0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    stop_cnt++; in_frame = 0;
  end
  always @(posedge scl_line) begin
    t_rise = $time;
    if (in_frame) begin
      if (bitcnt < 8) begin
        shreg = {shreg[6:0], sda_line};
        bitcnt++;
        if (bitcnt == 8) begin
          byte_no++;
          if (exp_q.size() == 0) chk("R6 unexpected byte", {24'd0, shreg}, 32'hFFFF_FFFF);
          else chk(tag_q.pop_front(), {24'd0, shreg}, {24'd0, exp_q.pop_front()});
        end
      end else if (bitcnt == 8) bitcnt = 9;
    end
  end
  always @(negedge scl_line) begin
    if (in_frame && bitcnt >= 1 && ($time - t_rise) != HI_TIME) hi_bad++;
    if (bitcnt == 8) ack_pull = ((byte_no - 1) != nack_at);   // R5 ack/nack
    else if (bitcnt == 9) begin ack_pull = 0; bitcnt = 0; end
  end
  always @(negedge clk) if (!rst && done) done_cnt++;

  task automatic clear_mon();
    start_cnt = 0; stop_cnt = 0; byte_no = 0; done_cnt = 0; hi_bad = 0;
    in_frame = 0; bitcnt = 0; ack_pull = 0;
  endtask

  task automatic run(string name, int nack, int n_bytes, bit exp_err, bit hold);
    int viol = 0;
    int writes = (n_bytes > 3) ? 2 : 1;
    rst = 1; hold_pull = hold; nack_at = nack;
    exp_q.delete(); tag_q.delete();
    repeat (4) @(negedge clk);
    clear_mon();
    chk("R1 reset busy", {31'd0, busy}, 1);
    chk("R10 reset lines", {30'd0, scl_oe, sda_oe}, 0);
    chk("R6 reset error/done", {30'd0, error, done}, 0);
    push_exp(n_bytes);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after release", {31'd0, busy}, 1);
    if (hold) begin
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (scl_oe || sda_oe || !busy) viol++;
      end
      chk("R9 no drive while bus held", viol, 0);
      hold_pull = 0;
      #1 clear_mon();
    end
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    $display("scenario %s", name);
    chk("R3 all expected bytes seen", exp_q.size(), 0);
    chk("R6 byte count", byte_no, n_bytes);
    chk("R3 start count", start_cnt, writes);
    chk("R6 stop count", stop_cnt, writes);
    chk("R7 done pulses", done_cnt, exp_err ? 0 : 1);
    chk("R6 error flag", {31'd0, error}, {31'd0, exp_err});
    chk("R10 idle after run", {29'd0, busy, scl_oe, sda_oe}, 0);
    chk("R8 scl high time", hi_bad, 0);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1;
    n_bad++;
    $display("FAIL watchdog run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run("all ack",            -1, 6, 0, 0);
    run("nack address",        0, 1, 1, 0);
    run("nack second offset",  4, 5, 1, 0);
    run("nack last data",      5, 6, 1, 0);
    run("bus held at start",  -1, 6, 0, 1);
    if (!wd_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule